// File: doc/BRIEF.md
# Per-Port Receive Statistics Counters

This block keeps a bank of statistics counters for each receive port. At the end of every packet the receive path sends one event record on a valid/ready stream. The record carries the port number, the frame length in bytes with the CRC included, an FCS error flag, a receive error flag, the class of the destination address and the parse mode. The block sorts the record into the counters it affects and updates all of them in the same clock cycle. The counters cover packet and octet totals, multicast and broadcast frames, a seven-bin length histogram, undersize and oversize frames split by FCS status, and good and errored inbound packets. Every counter saturates at its maximum value instead of wrapping.

Software reads any counter through a request/response stream by giving a port and a counter index. A configuration write sets two values: the largest legal frame length, and a global flag that makes every read reset the counter it returns.

Back-pressure rules. The event stream never stalls: `ev_ready` is tied high. A read request is taken when `rd_valid` and `rd_ready` are both high. `rd_ready` is high whenever no response is pending or the pending response is consumed in the same cycle. A response stays valid, with unchanged data, until `rd_resp_ready` is high.

Top module: `rx_port_stats`

## Requirements
- R1: `ev_ready` is always high. Each accepted event adds 1 to the total packets counter (index 0). It adds the length minus 4, floored at 0, to the payload octets counter (index 1).
- R2: Each accepted event adds its full length, CRC included, to the 64-bit inbound octets counter (index 16).
- R3: An event with the receive error flag set adds 1 to the 16-bit inbound error counter (index 17). Any other event adds 1 to the inbound good packets counter (index 15).
- R4: The destination class uses 1 for multicast and 2 for broadcast; 0 and 3 count as neither. Multicast (index 2) and broadcast (index 3) are counted only when the parse mode equals 1 (layer-2 parsing). A frame increments at most one of the two.
- R5: A frame of legal size increments exactly one histogram bin. The bins are: 64 (index 4), 65–127 (5), 128–255 (6), 256–511 (7), 512–1023 (8), 1024–1518 (9) and 1519 up to the programmed maximum (10).
- R6: A length below 64 increments the runt counter (index 11). If the FCS error flag is also set, it increments the runt-with-FCS-error counter (index 12) instead. Such a frame enters no histogram bin.
- R7: A length above the programmed maximum increments the oversize counter (index 13). If the FCS error flag is also set, it increments the oversize-with-FCS-error counter (index 14) instead. Such a frame enters no histogram bin.
- R8: The maximum length resets to 1518. A configuration write loads a new value. A length equal to the maximum is legal; one byte more is oversize.
- R9: A read taken in cycle t presents the selected counter, zero-extended to 64 bits, after the next clock edge. An index of 18 or above returns 0.
- R10: While a response is pending and `rd_resp_ready` is low, `rd_ready` is low and `rd_resp_valid` and `rd_resp_data` hold.
- R11: With the read-clear flag set, a read returns the counter and resets it to zero. With the flag clear, reading leaves the counter unchanged.
- R12: When a clearing read and an update reach the same counter in the same cycle, the read returns the old value and the counter becomes the increment alone.
- R13: Counters saturate at all ones for their width (16, 32 or 64 bits) and never wrap.
- R14: An event changes only the counters of its own port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | End-of-packet event valid |
| ev_ready | output | 1 | Event accepted (always high) |
| ev_port | input | PORT_W | Port of the event |
| ev_len | input | LEN_W | Frame length in bytes, CRC included |
| ev_fcs_err | input | 1 | Frame had an FCS error |
| ev_rx_err | input | 1 | Frame had a receive-interface error |
| ev_da_class | input | 2 | Destination class: 0 unicast, 1 multicast, 2 broadcast |
| ev_parse_mode | input | 2 | Parse mode; 1 means layer-2 parsing |
| cfg_we | input | 1 | Load the configuration fields |
| cfg_rd_clear | input | 1 | New read-clear flag |
| cfg_max_len | input | LEN_W | New maximum frame length |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted |
| rd_port | input | PORT_W | Port to read |
| rd_index | input | 5 | Counter index to read |
| rd_resp_valid | output | 1 | Read response valid |
| rd_resp_ready | input | 1 | Read response consumed |
| rd_resp_data | output | 64 | Counter value, zero-extended |

## Verification
The bench probes every histogram edge (64/65, 127/128, 255/256, 511/512, 1023/1024, 1518/1519), the lengths one byte either side of a reprogrammed maximum, and lengths of 63 and 3. An off-by-one comparator would move a frame into a neighbouring bin or into the runt or oversize counters. Broadcast frames, and multicast frames in other parse modes, are sent to catch a design that double-counts or ignores the parse mode. A clearing read is made in the same cycle as an update to that counter; a design that drops the increment, or that returns the new value, reads back the wrong number. The 16-bit error counter is driven past 65535; a wrapping design reads back a small value. A stalled response is held over a second request to catch a design whose data changes under back-pressure.

// File: rtl/rx_stats_pkg.sv
package rx_stats_pkg;

  localparam int NCNT  = 18;
  localparam int IDX_W = $clog2(NCNT);
  localparam int DATA_W = 64;

  // counter index map (software-visible)
  localparam int CI_PKTS      = 0;
  localparam int CI_PAY_OCTS  = 1;
  localparam int CI_MCAST     = 2;
  localparam int CI_BCAST     = 3;
  localparam int CI_HIST0     = 4;   // seven bins: 4..10
  localparam int HIST_BINS    = 7;
  localparam int CI_RUNT      = 11;
  localparam int CI_RUNT_FCS  = 12;
  localparam int CI_OVER      = 13;
  localparam int CI_OVER_FCS  = 14;
  localparam int CI_INB_PKTS  = 15;
  localparam int CI_INB_OCTS  = 16;
  localparam int CI_INB_ERRS  = 17;

  typedef enum logic [1:0] {
    DA_UNICAST = 2'd0,
    DA_MULTI   = 2'd1,
    DA_BCAST   = 2'd2,
    DA_OTHER   = 2'd3
  } da_class_e;

  typedef enum logic [1:0] {
    PM_RAW   = 2'd0,
    PM_L2    = 2'd1,
    PM_L3    = 2'd2,
    PM_OTHER = 2'd3
  } parse_mode_e;

  // width of each counter
  function automatic int cnt_width(int idx);
    if (idx == CI_INB_OCTS) return 64;
    if (idx == CI_INB_ERRS) return 16;
    return 32;
  endfunction

  // inclusive lower bound of a histogram bin
  function automatic int hist_lo(int bin);
    case (bin)
      0: return 64;
      1: return 65;
      2: return 128;
      3: return 256;
      4: return 512;
      5: return 1024;
      default: return 1519;
    endcase
  endfunction

  // inclusive upper bound of the fixed bins (bin 6 ends at the programmed max)
  function automatic int hist_hi(int bin);
    case (bin)
      0: return 64;
      1: return 127;
      2: return 255;
      3: return 511;
      4: return 1023;
      default: return 1518;
    endcase
  endfunction

endpackage

// File: rtl/rx_stats_classify.sv
module rx_stats_classify
  import rx_stats_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int MIN_LEN = 64
) (
  input  logic             fire,
  input  logic [LEN_W-1:0] len,
  input  logic             fcs_err,
  input  logic             rx_err,
  input  logic [1:0]       da_class,
  input  logic [1:0]       parse_mode,
  input  logic [LEN_W-1:0] max_len,
  output logic [NCNT-1:0]  inc_en,
  output logic [LEN_W-1:0] pay_len
);

  localparam logic [LEN_W-1:0] CRC_BYTES = LEN_W'(4);

  logic is_runt, is_over, legal;
  logic l2_mode;
  da_class_e cls;

  assign cls     = da_class_e'(da_class);
  assign l2_mode = (parse_mode_e'(parse_mode) == PM_L2);
  assign is_runt = (len < LEN_W'(MIN_LEN));
  assign is_over = !is_runt && (len > max_len);
  assign legal   = !is_runt && !is_over;
  assign pay_len = (len >= CRC_BYTES) ? (len - CRC_BYTES) : '0;

  logic [HIST_BINS-1:0] bin_hit;

  for (genvar b = 0; b < HIST_BINS; b++) begin : g_bin
    if (b == HIST_BINS - 1) begin : g_top
      // last bin is bounded above by the programmed maximum (via legal)
      assign bin_hit[b] = legal && (len >= LEN_W'(hist_lo(b)));
    end else begin : g_fixed
      assign bin_hit[b] = legal && (len >= LEN_W'(hist_lo(b)))
                                && (len <= LEN_W'(hist_hi(b)));
    end
  end

  always_comb begin
    inc_en = '0;
    if (fire) begin
      inc_en[CI_PKTS]     = 1'b1;
      inc_en[CI_PAY_OCTS] = 1'b1;
      inc_en[CI_INB_OCTS] = 1'b1;
      inc_en[CI_INB_ERRS] = rx_err;
      inc_en[CI_INB_PKTS] = !rx_err;
      inc_en[CI_MCAST]    = l2_mode && (cls == DA_MULTI);
      inc_en[CI_BCAST]    = l2_mode && (cls == DA_BCAST);
      inc_en[CI_HIST0 +: HIST_BINS] = bin_hit;
      inc_en[CI_RUNT]     = is_runt && !fcs_err;
      inc_en[CI_RUNT_FCS] = is_runt && fcs_err;
      inc_en[CI_OVER]     = is_over && !fcs_err;
      inc_en[CI_OVER_FCS] = is_over && fcs_err;
    end
  end

endmodule

// File: rtl/rx_stats_counter.sv
module rx_stats_counter #(
  parameter int W  = 32,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic [AW-1:0] amt,
  input  logic          clr,
  output logic [W-1:0]  value
);

  logic [W-1:0] base;
  logic [W:0]   sum;
  logic [W-1:0] nxt;

  // a clear in the same cycle as an increment leaves just the increment
  assign base = clr ? '0 : value;
  assign sum  = {1'b0, base} + {{(W + 1 - AW){1'b0}}, amt};
  assign nxt  = inc ? (sum[W] ? {W{1'b1}} : sum[W-1:0]) : base;

  always_ff @(posedge clk) begin
    if (!rst_n) value <= '0;
    else        value <= nxt;
  end

endmodule

// File: rtl/rx_stats_rdport.sv
module rx_stats_rdport #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  output logic          req_fire,
  input  logic [DW-1:0] sel_value,
  output logic          resp_valid,
  input  logic          resp_ready,
  output logic [DW-1:0] resp_data
);

  assign req_ready = !resp_valid || resp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else if (req_fire) begin
      resp_valid <= 1'b1;
      resp_data  <= sel_value;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/rx_port_stats.sv
module rx_port_stats
  import rx_stats_pkg::*;
#(
  parameter int NPORTS      = 2,
  parameter int LEN_W       = 16,
  parameter int MIN_LEN     = 64,
  parameter int DEF_MAX_LEN = 1518,
  localparam int PORT_W     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [PORT_W-1:0] ev_port,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic              ev_fcs_err,
  input  logic              ev_rx_err,
  input  logic [1:0]        ev_da_class,
  input  logic [1:0]        ev_parse_mode,
  input  logic              cfg_we,
  input  logic              cfg_rd_clear,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [PORT_W-1:0] rd_port,
  input  logic [IDX_W-1:0]  rd_index,
  output logic              rd_resp_valid,
  input  logic              rd_resp_ready,
  output logic [DATA_W-1:0] rd_resp_data
);

  // ---------------- configuration ----------------
  logic             rd_clear_q;
  logic [LEN_W-1:0] max_len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_clear_q <= 1'b0;
      max_len_q  <= LEN_W'(DEF_MAX_LEN);
    end else if (cfg_we) begin
      rd_clear_q <= cfg_rd_clear;
      max_len_q  <= cfg_max_len;
    end
  end

  // ---------------- event classification ----------------
  logic            ev_fire;
  logic [NCNT-1:0] inc_en;
  logic [LEN_W-1:0] pay_len;

  assign ev_ready = 1'b1;
  assign ev_fire  = ev_valid && (int'(ev_port) < NPORTS);

  rx_stats_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_cls (
    .fire       (ev_fire),
    .len        (ev_len),
    .fcs_err    (ev_fcs_err),
    .rx_err     (ev_rx_err),
    .da_class   (ev_da_class),
    .parse_mode (ev_parse_mode),
    .max_len    (max_len_q),
    .inc_en     (inc_en),
    .pay_len    (pay_len)
  );

  // ---------------- read request path ----------------
  logic              rd_fire;
  logic [DATA_W-1:0] sel_value;
  logic [DATA_W-1:0] cnt_val [NPORTS][NCNT];

  always_comb begin
    sel_value = '0;
    for (int p = 0; p < NPORTS; p++) begin
      for (int j = 0; j < NCNT; j++) begin
        if (rd_port == PORT_W'(p) && rd_index == IDX_W'(j))
          sel_value = cnt_val[p][j];
      end
    end
  end

  rx_stats_rdport #(.DW(DATA_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (rd_valid),
    .req_ready  (rd_ready),
    .req_fire   (rd_fire),
    .sel_value  (sel_value),
    .resp_valid (rd_resp_valid),
    .resp_ready (rd_resp_ready),
    .resp_data  (rd_resp_data)
  );

  // ---------------- counter bank ----------------
  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic port_hit;
    logic port_rd;
    assign port_hit = ev_fire && (ev_port == PORT_W'(p));
    assign port_rd  = rd_fire && rd_clear_q && (rd_port == PORT_W'(p));

    for (genvar j = 0; j < NCNT; j++) begin : g_cnt
      localparam int CW = cnt_width(j);
      logic [LEN_W-1:0] amt;
      logic [CW-1:0]    q;

      if (j == CI_PAY_OCTS) begin : g_pay
        assign amt = pay_len;
      end else if (j == CI_INB_OCTS) begin : g_all
        assign amt = ev_len;
      end else begin : g_one
        assign amt = LEN_W'(1);
      end

      rx_stats_counter #(.W(CW), .AW(LEN_W)) u_c (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (port_hit && inc_en[j]),
        .amt   (amt),
        .clr   (port_rd && (rd_index == IDX_W'(j))),
        .value (q)
      );

      assign cnt_val[p][j] = DATA_W'(q);
    end
  end

endmodule

// File: rtl/rx_port_stats_chk.sv
module rx_port_stats_chk
  import rx_stats_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_fire,
  input logic [LEN_W-1:0] ev_len,
  input logic             ev_fcs_err,
  input logic [1:0]       ev_parse_mode,
  input logic [LEN_W-1:0] max_len,
  input logic [NCNT-1:0]  inc_en,
  input logic             rd_ready,
  input logic             rd_resp_valid,
  input logic             rd_resp_ready,
  input logic [63:0]      rd_resp_data
);

  p_mc_bc_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_en[CI_MCAST] && inc_en[CI_BCAST]));

  p_class_l2only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en[CI_MCAST] || inc_en[CI_BCAST]) |-> (ev_parse_mode == 2'd1));

  p_one_bin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_len >= LEN_W'(64) && ev_len <= max_len)
      |-> ($countones(inc_en[CI_HIST0 +: HIST_BINS]) == 1));

  p_runt_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_len < LEN_W'(64))
      |-> (inc_en[CI_RUNT_FCS] == ev_fcs_err) && (inc_en[CI_RUNT] == !ev_fcs_err)
          && (inc_en[CI_HIST0 +: HIST_BINS] == '0));

  p_over_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_fire && ev_len > max_len && ev_len >= LEN_W'(64))
      |-> (inc_en[CI_OVER_FCS] == ev_fcs_err) && (inc_en[CI_OVER] == !ev_fcs_err)
          && (inc_en[CI_HIST0 +: HIST_BINS] == '0));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp_valid && !rd_resp_ready) |=> (rd_resp_valid && $stable(rd_resp_data)));

  p_stall_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_resp_valid && !rd_resp_ready) |-> !rd_ready);

endmodule

bind rx_port_stats rx_port_stats_chk #(.LEN_W(LEN_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_fire       (ev_fire),
  .ev_len        (ev_len),
  .ev_fcs_err    (ev_fcs_err),
  .ev_parse_mode (ev_parse_mode),
  .max_len       (max_len_q),
  .inc_en        (inc_en),
  .rd_ready      (rd_ready),
  .rd_resp_valid (rd_resp_valid),
  .rd_resp_ready (rd_resp_ready),
  .rd_resp_data  (rd_resp_data)
);

// File: tb/sim_rx_port_stats.sv
module sim_rx_port_stats;

  localparam int NC = 18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [0:0]  ev_port = '0;
  logic [15:0] ev_len = '0;
  logic        ev_fcs_err = 1'b0;
  logic        ev_rx_err = 1'b0;
  logic [1:0]  ev_da_class = '0;
  logic [1:0]  ev_parse_mode = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_rd_clear = 1'b0;
  logic [15:0] cfg_max_len = 16'd1518;
  logic        rd_valid = 1'b0;
  logic        rd_ready;
  logic [0:0]  rd_port = '0;
  logic [4:0]  rd_index = '0;
  logic        rd_resp_valid;
  logic        rd_resp_ready = 1'b1;
  logic [63:0] rd_resp_data;

  always #2 clk = ~clk;

  rx_port_stats u0 (
    .clk(clk), .rst_n(rst_n),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_port(ev_port), .ev_len(ev_len),
    .ev_fcs_err(ev_fcs_err), .ev_rx_err(ev_rx_err), .ev_da_class(ev_da_class),
    .ev_parse_mode(ev_parse_mode),
    .cfg_we(cfg_we), .cfg_rd_clear(cfg_rd_clear), .cfg_max_len(cfg_max_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_port(rd_port), .rd_index(rd_index),
    .rd_resp_valid(rd_resp_valid), .rd_resp_ready(rd_resp_ready),
    .rd_resp_data(rd_resp_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [63:0] mdl [2][NC];

  // stimulus vector: port, len, fcs, rx_err, class, mode, expected size counter
  typedef struct packed {
    logic [0:0]  port;
    logic [15:0] len;
    logic        fcs;
    logic        rxe;
    logic [1:0]  cls;
    logic [1:0]  pm;
    logic [4:0]  bin;
  } vec_t;

  localparam int NV = 18;
  localparam logic [27:0] VECS [NV] = '{
    {1'b0, 16'd64,   1'b0, 1'b0, 2'd0, 2'd1, 5'd4},   // R5 smallest bin
    {1'b0, 16'd65,   1'b0, 1'b0, 2'd1, 2'd1, 5'd5},   // R4 multicast, R5
    {1'b0, 16'd127,  1'b0, 1'b0, 2'd2, 2'd1, 5'd5},   // R4 broadcast
    {1'b0, 16'd128,  1'b0, 1'b0, 2'd1, 2'd2, 5'd6},   // R4 multicast not in L2 mode
    {1'b0, 16'd255,  1'b0, 1'b0, 2'd0, 2'd0, 5'd6},
    {1'b0, 16'd256,  1'b0, 1'b0, 2'd0, 2'd1, 5'd7},
    {1'b0, 16'd511,  1'b1, 1'b0, 2'd0, 2'd1, 5'd7},   // FCS alone does not move a legal frame
    {1'b0, 16'd512,  1'b0, 1'b0, 2'd0, 2'd1, 5'd8},
    {1'b0, 16'd1023, 1'b0, 1'b0, 2'd0, 2'd1, 5'd8},
    {1'b0, 16'd1024, 1'b0, 1'b0, 2'd0, 2'd1, 5'd9},
    {1'b0, 16'd1518, 1'b0, 1'b0, 2'd2, 2'd1, 5'd9},   // R8 max is legal
    {1'b0, 16'd1519, 1'b0, 1'b0, 2'd0, 2'd1, 5'd13},  // R7 oversize
    {1'b0, 16'd1519, 1'b1, 1'b0, 2'd0, 2'd1, 5'd14},  // R7 oversize + FCS
    {1'b0, 16'd63,   1'b0, 1'b0, 2'd0, 2'd1, 5'd11},  // R6 runt
    {1'b0, 16'd10,   1'b1, 1'b0, 2'd0, 2'd1, 5'd12},  // R6 runt + FCS
    {1'b1, 16'd3,    1'b1, 1'b1, 2'd0, 2'd1, 5'd12},  // R1 floor, R3 error
    {1'b1, 16'd200,  1'b0, 1'b1, 2'd1, 2'd3, 5'd6},   // R3, R4 mode 3
    {1'b1, 16'd64,   1'b0, 1'b0, 2'd2, 2'd1, 5'd4}    // R14 other port
  };

  function automatic logic [63:0] sat_add(int idx, logic [63:0] old, logic [63:0] add);
    logic [63:0] maxv;
    int w;
    w = (idx == 16) ? 64 : (idx == 17) ? 16 : 32;
    maxv = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    if (add > maxv - old) return maxv;
    return old + add;
  endfunction

  function automatic string req_of(int idx);
    case (idx)
      0, 1: return "R1";
      16: return "R2";
      15, 17: return "R3";
      2, 3: return "R4";
      11, 12: return "R6";
      13, 14: return "R7";
      default: return "R5";
    endcase
  endfunction

  task automatic model_ev(int p, int len, bit fcs, bit rxe, int cls, int pm, int bin);
    mdl[p][0]  = sat_add(0, mdl[p][0], 1);
    mdl[p][1]  = sat_add(1, mdl[p][1], (len >= 4) ? 64'(len - 4) : 64'd0);
    mdl[p][16] = sat_add(16, mdl[p][16], 64'(len));
    if (rxe) mdl[p][17] = sat_add(17, mdl[p][17], 1);
    else     mdl[p][15] = sat_add(15, mdl[p][15], 1);
    if (pm == 1 && cls == 1) mdl[p][2] = sat_add(2, mdl[p][2], 1);
    if (pm == 1 && cls == 2) mdl[p][3] = sat_add(3, mdl[p][3], 1);
    mdl[p][bin] = sat_add(bin, mdl[p][bin], 1);
    if (fcs && 0) mdl[p][bin] = mdl[p][bin];
  endtask

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive_ev(int p, int len, bit fcs, bit rxe, int cls, int pm);
    ev_valid = 1'b1; ev_port = 1'(p); ev_len = 16'(len);
    ev_fcs_err = fcs; ev_rx_err = rxe; ev_da_class = 2'(cls); ev_parse_mode = 2'(pm);
  endtask

  task automatic send_ev(int p, int len, bit fcs, bit rxe, int cls, int pm, int bin);
    @(negedge clk);
    drive_ev(p, len, fcs, rxe, cls, pm);
    @(negedge clk);
    ev_valid = 1'b0;
    model_ev(p, len, fcs, rxe, cls, pm, bin);
  endtask

  task automatic do_read(int p, int idx, output logic [63:0] d);
    @(negedge clk);
    rd_valid = 1'b1; rd_port = 1'(p); rd_index = 5'(idx);
    @(negedge clk);
    rd_valid = 1'b0;
    d = rd_resp_data;
  endtask

  task automatic set_cfg(bit clr, int maxl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_rd_clear = clr; cfg_max_len = 16'(maxl);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    for (int p = 0; p < 2; p++) for (int i = 0; i < NC; i++) mdl[p][i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("R1 ev_ready", 64'(ev_ready), 64'd1);
    check("R10 rd_ready after reset", 64'(rd_ready), 64'd1);
    check("R9 no response after reset", 64'(rd_resp_valid), 64'd0);
    do_read(0, 0, d);
    check("R1 reset count", d, 64'd0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      vec_t t;
      t = vec_t'(VECS[v]);
      send_ev(int'(t.port), int'(t.len), t.fcs, t.rxe, int'(t.cls), int'(t.pm), int'(t.bin));
    end
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < NC; i++) begin
        do_read(p, i, d);
        check($sformatf("%s/R14 port %0d idx %0d", req_of(i), p, i), d, mdl[p][i]);
      end
    end

    // R9: out-of-range index
    do_read(0, 20, d);
    check("R9 unused index", d, 64'd0);

    // R8: reprogram maximum length
    set_cfg(1'b0, 1600);
    send_ev(0, 1600, 1'b0, 1'b0, 0, 0, 10);
    send_ev(0, 1601, 1'b0, 1'b0, 0, 0, 13);
    do_read(0, 10, d);
    check("R8 len equal to new max in top bin", d, mdl[0][10]);
    do_read(0, 13, d);
    check("R8 one past new max is oversize", d, mdl[0][13]);

    // R11: read with and without clear
    do_read(0, 5, d);
    check("R11 non-clearing read", d, mdl[0][5]);
    do_read(0, 5, d);
    check("R11 value kept after plain read", d, mdl[0][5]);
    set_cfg(1'b1, 1600);
    do_read(0, 4, d);
    check("R11 clearing read returns value", d, mdl[0][4]);
    mdl[0][4] = '0;
    do_read(0, 4, d);
    check("R11 counter zero after clearing read", d, 64'd0);

    // R12: clearing read and update on the same counter in one cycle
    @(negedge clk);
    drive_ev(0, 100, 1'b0, 1'b0, 0, 0);
    rd_valid = 1'b1; rd_port = 1'b0; rd_index = 5'd5;
    @(negedge clk);
    ev_valid = 1'b0; rd_valid = 1'b0;
    check("R12 read returns old value", rd_resp_data, mdl[0][5]);
    mdl[0][5] = '0;
    model_ev(0, 100, 1'b0, 1'b0, 0, 0, 5);
    do_read(0, 5, d);
    check("R12 increment survives clear", d, 64'd1);
    mdl[0][5] = '0;
    set_cfg(1'b0, 1600);

    // R10: back-pressure on the response
    @(negedge clk);
    rd_resp_ready = 1'b0;
    rd_valid = 1'b1; rd_port = 1'b0; rd_index = 5'd0;
    @(negedge clk);
    check("R10 response valid", 64'(rd_resp_valid), 64'd1);
    check("R10 first data", rd_resp_data, mdl[0][0]);
    check("R10 request blocked", 64'(rd_ready), 64'd0);
    rd_index = 5'd16;
    @(negedge clk);
    check("R10 data held", rd_resp_data, mdl[0][0]);
    check("R10 still blocked", 64'(rd_ready), 64'd0);
    rd_resp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R10 second data after release", rd_resp_data, mdl[0][16]);
    @(negedge clk);
    check("R10 response drains", 64'(rd_resp_valid), 64'd0);

    // R13: saturate the 16-bit error counter on port 1
    @(negedge clk);
    drive_ev(1, 64, 1'b0, 1'b1, 0, 0);
    repeat (65540) @(negedge clk);
    ev_valid = 1'b0;
    for (int k = 0; k < 65540; k++) model_ev(1, 64, 1'b0, 1'b1, 0, 0, 4);
    do_read(1, 17, d);
    check("R13 error counter saturates", d, 64'd65535);
    do_read(1, 16, d);
    check("R13/R2 wide octet counter keeps counting", d, mdl[1][16]);
    do_read(1, 15, d);
    check("R3 good count untouched by errored frames", d, mdl[1][15]);
    do_read(0, 17, d);
    check("R14 other port untouched", d, mdl[0][17]);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule